// File: doc/BRIEF.md
# Multi-Level Virtual Address Translator

This block maps a 64-bit virtual address to a real address by walking a chain of translation tables held in memory. A request carries the virtual address, a 2-bit code naming the kind of table the walk begins with, and that table's real origin. The walk then descends one level per memory read: optional region levels (first, second, third), then the segment level, then the page level. It ends with the page frame joined to the byte offset, or with a 3-bit exception code.

Before any table is read, the block checks that the named starting table can reach the address. A high-order index field that is nonzero calls for a start at least at the table that field indexes. If the start is too low, the request ends at once with a range exception.

Both ports are valid/ready streams. On the request side the caller holds `req_valid` and its fields steady until `req_ready` is seen high at a clock edge. `req_ready` stays low for the whole walk, so at most one translation is in progress. On the memory side the block holds `mem_rd_valid` and `mem_rd_addr` steady until `mem_rd_ready` is high at an edge. It then waits for a single `mem_rsp_valid` beat, which carries the entry. The response side has no back-pressure: the result appears as a one-cycle `done_valid` pulse and must be taken in that cycle.

Top module: `vat_translator`

## Requirements
- R1: Bit 0 is the most significant bit of the virtual address. The fields are:
  - region-first index: bits 0-10
  - region-second index: bits 11-21
  - region-third index: bits 22-32
  - segment index: bits 33-43
  - page index: bits 44-51
  - byte index: bits 52-63

  Each table read targets the current table origin plus eight times the index field of that level.
- R2: The start code selects the first table read:
  - 0: segment table
  - 1: region-third table
  - 2: region-second table
  - 3: region-first table

  The first read uses `req_asce_origin`. The walk then visits every lower level down to the page table, one read per level.
- R3: The required start is computed from the index fields:
  - region-first index nonzero: region-first table
  - otherwise, region-second index nonzero: region-second table
  - otherwise, region-third index nonzero: region-third table
  - otherwise: segment table

  If the start code names a lower table than required, no read is issued. `done_valid` pulses on the clock after acceptance with exception code 6. A higher start than required is allowed.
- R4: An entry whose bit 0 (LSB) is 1 is invalid. It ends the walk with a code that depends on the level read:
  - region-first: 1
  - region-second: 2
  - region-third: 3
  - segment: 4
  - page: 5

  On any exception `done_raddr` is zero.
- R5: For a valid entry above the page level, the next table origin is entry bits 63:12 (LSB numbering) followed by twelve zero bits. A valid page entry gives the result: `done_raddr` is entry bits 63:12 followed by the byte index, with `done_exc` 0.
- R6: At most one read is outstanding. `mem_rd_valid` stays low from a read handshake until its response arrives.
- R7: While `mem_rd_valid` is high and `mem_rd_ready` is low, `mem_rd_valid` stays high and `mem_rd_addr` stays unchanged.
- R8: `req_ready` is high when idle and low from acceptance until the walk ends. A request offered while busy is ignored and starts no reads.
- R9: `done_valid` is a one-cycle pulse on the clock after the final response, or after acceptance in the R3 case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_vaddr | input | 64 | Virtual address, bit 0 is the MSB |
| req_asce_type | input | 2 | Start table code (0 segment, 1 region-third, 2 region-second, 3 region-first) |
| req_asce_origin | input | 64 | Real origin of the start table |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 64 | Real address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry word (bit 0 invalid, bits 63:12 origin) |
| done_valid | output | 1 | One-cycle completion pulse |
| done_raddr | output | 64 | Real address, zero on exception |
| done_exc | output | 3 | 0 none, 1..5 invalid entry per level, 6 range |

## Verification
The hardest situation to bring about is a request arriving while a walk is stalled in read back-pressure. Reaching it requires a walk long enough to be mid-sequence, with `mem_rd_ready` held low at the moment a second request is offered. The stimulus holds the memory not-ready for several cycles at the start of a four-level walk, offering an unrelated request during those cycles. It then confirms that every later read address still follows the first request's chain. Invalid-entry codes are reached by planting the invalid bit at exactly one level of an otherwise valid five-level chain, once per level.

// File: rtl/vat_pkg.sv
package vat_pkg;
  localparam int VA_W      = 64;
  localparam int IDX_W     = 11;
  localparam int PX_W      = 8;
  localparam int BX_W      = 12;
  localparam int ENT_SHIFT = 3;
  localparam int N_RGN     = 3;

  typedef enum logic [2:0] {
    LV_PAGE = 3'd0,
    LV_SEG  = 3'd1,
    LV_R3   = 3'd2,
    LV_R2   = 3'd3,
    LV_R1   = 3'd4
  } lvl_e;

  typedef enum logic [2:0] {
    EX_NONE  = 3'd0,
    EX_R1    = 3'd1,
    EX_R2    = 3'd2,
    EX_R3    = 3'd3,
    EX_SEG   = 3'd4,
    EX_PAGE  = 3'd5,
    EX_RANGE = 3'd6
  } exc_e;

  function automatic exc_e lvl_to_exc(lvl_e l);
    case (l)
      LV_R1:   return EX_R1;
      LV_R2:   return EX_R2;
      LV_R3:   return EX_R3;
      LV_SEG:  return EX_SEG;
      default: return EX_PAGE;
    endcase
  endfunction
endpackage

// File: rtl/vat_range_check.sv
module vat_range_check
  import vat_pkg::*;
(
  input  logic [VA_W-1:0] vaddr,
  input  logic [1:0]      asce_type,
  output logic            range_err
);
  logic [N_RGN-1:0] nz;
  logic [1:0]       need;

  for (genvar g = 0; g < N_RGN; g++) begin : g_nz
    assign nz[g] = |vaddr[BX_W + PX_W + (g + 1) * IDX_W +: IDX_W];
  end

  always_comb begin
    need = 2'd0;
    for (int k = 0; k < N_RGN; k++) begin
      if (nz[k]) need = 2'(k + 1);
    end
  end

  assign range_err = (asce_type < need);
endmodule

// File: rtl/vat_index_sel.sv
module vat_index_sel
  import vat_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic [VA_W-1:0] vaddr,
  input  lvl_e            lvl,
  input  logic [AW-1:0]   origin,
  output logic [AW-1:0]   ent_addr
);
  logic [N_RGN+1:0][IDX_W-1:0] fld;
  logic [IDX_W-1:0]            idx;

  assign fld[0] = {{(IDX_W - PX_W){1'b0}}, vaddr[BX_W +: PX_W]};
  for (genvar g = 0; g <= N_RGN; g++) begin : g_fld
    assign fld[g + 1] = vaddr[BX_W + PX_W + g * IDX_W +: IDX_W];
  end

  always_comb begin
    case (lvl)
      LV_PAGE: idx = fld[0];
      LV_SEG:  idx = fld[1];
      LV_R3:   idx = fld[2];
      LV_R2:   idx = fld[3];
      default: idx = fld[4];
    endcase
  end

  assign ent_addr = origin + ({{(AW - IDX_W){1'b0}}, idx} << ENT_SHIFT);
endmodule

// File: rtl/vat_walk_ctl.sv
module vat_walk_ctl
  import vat_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_fire,
  input  logic            range_err,
  input  lvl_e            start_lvl,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [AW-1:0]   req_origin,
  input  logic            mem_rd_ready,
  input  logic            mem_rsp_valid,
  input  logic [AW-1:0]   mem_rsp_data,
  output logic            idle,
  output logic            rd_valid,
  output lvl_e            cur_lvl,
  output logic [AW-1:0]   cur_origin,
  output logic [VA_W-1:0] cur_vaddr,
  output logic            done_valid,
  output logic [AW-1:0]   done_raddr,
  output exc_e            done_exc
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_e;
  st_e  st;
  logic unused_bits;

  assign unused_bits = ^mem_rsp_data[BX_W-1:1];
  assign idle        = (st == S_IDLE);
  assign rd_valid    = (st == S_ISSUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cur_lvl    <= LV_PAGE;
      cur_origin <= '0;
      cur_vaddr  <= '0;
      done_valid <= 1'b0;
      done_raddr <= '0;
      done_exc   <= EX_NONE;
    end else begin
      done_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_fire) begin
          if (range_err) begin
            done_valid <= 1'b1;
            done_exc   <= EX_RANGE;
            done_raddr <= '0;
          end else begin
            cur_lvl    <= start_lvl;
            cur_origin <= req_origin;
            cur_vaddr  <= req_vaddr;
            st         <= S_ISSUE;
          end
        end
        S_ISSUE: if (mem_rd_ready) st <= S_WAIT;
        default: if (mem_rsp_valid) begin
          if (mem_rsp_data[0]) begin
            done_valid <= 1'b1;
            done_exc   <= lvl_to_exc(cur_lvl);
            done_raddr <= '0;
            st         <= S_IDLE;
          end else if (cur_lvl == LV_PAGE) begin
            done_valid <= 1'b1;
            done_exc   <= EX_NONE;
            done_raddr <= {mem_rsp_data[AW-1:BX_W], cur_vaddr[BX_W-1:0]};
            st         <= S_IDLE;
          end else begin
            cur_origin <= {mem_rsp_data[AW-1:BX_W], {BX_W{1'b0}}};
            cur_lvl    <= lvl_e'(cur_lvl - 3'd1);
            st         <= S_ISSUE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/vat_translator.sv
module vat_translator
  import vat_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [1:0]      req_asce_type,
  input  logic [AW-1:0]   req_asce_origin,
  output logic            mem_rd_valid,
  input  logic            mem_rd_ready,
  output logic [AW-1:0]   mem_rd_addr,
  input  logic            mem_rsp_valid,
  input  logic [AW-1:0]   mem_rsp_data,
  output logic            done_valid,
  output logic [AW-1:0]   done_raddr,
  output logic [2:0]      done_exc
);
  logic            range_err;
  logic            idle;
  lvl_e            start_lvl;
  lvl_e            cur_lvl;
  logic [AW-1:0]   cur_origin;
  logic [VA_W-1:0] cur_vaddr;
  exc_e            exc;

  assign start_lvl = lvl_e'(3'(req_asce_type) + 3'd1);
  assign req_ready = idle;
  assign done_exc  = exc;

  vat_range_check u_range (
    .vaddr     (req_vaddr),
    .asce_type (req_asce_type),
    .range_err (range_err)
  );

  vat_walk_ctl #(.AW(AW)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_fire      (req_valid && idle),
    .range_err     (range_err),
    .start_lvl     (start_lvl),
    .req_vaddr     (req_vaddr),
    .req_origin    (req_asce_origin),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .idle          (idle),
    .rd_valid      (mem_rd_valid),
    .cur_lvl       (cur_lvl),
    .cur_origin    (cur_origin),
    .cur_vaddr     (cur_vaddr),
    .done_valid    (done_valid),
    .done_raddr    (done_raddr),
    .done_exc      (exc)
  );

  vat_index_sel #(.AW(AW)) u_idx (
    .vaddr    (cur_vaddr),
    .lvl      (cur_lvl),
    .origin   (cur_origin),
    .ent_addr (mem_rd_addr)
  );
endmodule

// File: rtl/vat_translator_chk.sv
module vat_translator_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_vaddr,
  input logic [1:0]  req_asce_type,
  input logic [63:0] req_asce_origin,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [63:0] mem_rd_addr,
  input logic        mem_rsp_valid,
  input logic [63:0] mem_rsp_data,
  input logic        done_valid,
  input logic [63:0] done_raddr,
  input logic [2:0]  done_exc
);
  logic       outst;
  logic [1:0] need;
  logic       accept;

  assign accept = req_valid && req_ready;

  always_comb begin
    if (req_vaddr[63:53] != 0)      need = 2'd3;
    else if (req_vaddr[52:42] != 0) need = 2'd2;
    else if (req_vaddr[41:31] != 0) need = 2'd1;
    else                            need = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= 1'b0;
    else if (mem_rd_valid && mem_rd_ready) outst <= 1'b1;
    else if (mem_rsp_valid) outst <= 1'b0;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !mem_rd_valid); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R7
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !req_ready); // R8
  AST_RANGE_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_asce_type < need)) |=> (done_valid && done_exc == 3'd6 && !mem_rd_valid)); // R3
  AST_EXC_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_exc != 3'd0) |-> (done_raddr == 64'd0)); // R4
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> ($past(mem_rsp_valid) || $past(accept))); // R9
endmodule

bind vat_translator vat_translator_chk u_chk (.*);

// File: tb/vat_translator_tb.sv
module vat_translator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_asce_type = '0;
  logic [63:0] req_asce_origin = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [63:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done_valid;
  logic [63:0] done_raddr;
  logic [2:0]  done_exc;

  int checks = 0;
  int errors = 0;
  logic [63:0] tbl [logic [63:0]];

  always #4 clk = ~clk;

  vat_translator u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // field by MSB-0 bit numbering
  function automatic logic [63:0] fld(input logic [63:0] va, input int first, input int last);
    return (va >> (63 - last)) & ((64'd1 << (last - first + 1)) - 64'd1);
  endfunction

  function automatic logic [63:0] idx_of(input logic [63:0] va, input int lvl);
    case (lvl)
      4: return fld(va, 0, 10);
      3: return fld(va, 11, 21);
      2: return fld(va, 22, 32);
      1: return fld(va, 33, 43);
      default: return fld(va, 44, 51);
    endcase
  endfunction

  function automatic logic [63:0] rd_tbl(input logic [63:0] a);
    if (tbl.exists(a)) return tbl[a];
    return 64'h1;
  endfunction

  task automatic mkchain(input logic [63:0] va, input int typ, input logic [63:0] root,
                         input logic [63:0] base, input logic [63:0] frame, input int bad);
    logic [63:0] org = root;
    for (int l = typ + 1; l >= 0; l--) begin
      logic [63:0] a = org + idx_of(va, l) * 8;
      logic [63:0] nxt = base + 64'(l) * 64'h10000;
      tbl[a] = (l == 0) ? {frame[63:12], 12'h0} : nxt;
      if (l == bad) tbl[a] = tbl[a] | 64'h1;
      org = nxt;
    end
  endtask

  task automatic run(input logic [63:0] va, input int typ, input logic [63:0] root,
                     input int stall, input int lat);
    logic [63:0] q[$];
    logic [63:0] org = root;
    logic [63:0] ent;
    int need, exc, l;
    logic [63:0] ra = '0;
    string tg;
    need = (fld(va,0,10) != 0) ? 3 : (fld(va,11,21) != 0) ? 2 : (fld(va,22,32) != 0) ? 1 : 0;
    exc = 0;
    if (typ < need) exc = 6;
    else begin
      l = typ + 1;
      forever begin
        q.push_back(org + idx_of(va, l) * 8);
        ent = rd_tbl(q[$]);
        if (ent[0]) begin exc = 5 - l; break; end
        if (l == 0) begin ra = {ent[63:12], fld(va, 52, 63)[11:0]}; break; end
        org = {ent[63:12], 12'h0};
        l--;
      end
    end
    chk(req_ready == 1'b1, "R8 idle ready", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_vaddr = va; req_asce_type = 2'(typ); req_asce_origin = root;
    @(negedge clk);
    req_valid = 1'b0;
    foreach (q[i]) begin
      for (int s = 0; s < stall; s++) begin
        req_valid = 1'b1; req_vaddr = ~va; req_asce_type = 2'd3; req_asce_origin = 64'h7000_0000;
        chk(mem_rd_valid && mem_rd_addr == q[i], "R7 held read", mem_rd_addr, q[i]);
        chk(req_ready == 1'b0, "R8 busy", 64'(req_ready), 64'd0);
        @(negedge clk);
      end
      req_valid = 1'b0;
      tg = (i == 0) ? "R2 first read" : "R1 entry addr";
      chk(mem_rd_valid == 1'b1, tg, 64'(mem_rd_valid), 64'd1);
      chk(mem_rd_addr == q[i], tg, mem_rd_addr, q[i]);
      mem_rd_ready = 1'b1;
      @(negedge clk);
      mem_rd_ready = 1'b0;
      for (int w = 0; w < lat; w++) begin
        chk(!mem_rd_valid && !done_valid, "R6 waiting", 64'(mem_rd_valid), 64'd0);
        @(negedge clk);
      end
      chk(!mem_rd_valid, "R6 no second read", 64'(mem_rd_valid), 64'd0);
      mem_rsp_valid = 1'b1; mem_rsp_data = rd_tbl(q[i]);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (i != q.size() - 1)
        chk(!done_valid, "R9 early done", 64'(done_valid), 64'd0);
    end
    tg = (exc == 6) ? "R3" : (exc != 0) ? "R4" : "R5";
    chk(done_valid == 1'b1, "R9 done pulse", 64'(done_valid), 64'd1);
    chk(64'(done_exc) == 64'(exc), tg, 64'(done_exc), 64'(exc));
    chk(done_raddr == ra, tg, done_raddr, ra);
    if (exc == 6) chk(!mem_rd_valid, "R3 no read", 64'(mem_rd_valid), 64'd0);
    @(negedge clk);
    chk(!done_valid, "R9 single cycle", 64'(done_valid), 64'd0);
    chk(!mem_rd_valid, "R8 stray request", 64'(mem_rd_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R8 reset ready", 64'(req_ready), 64'd1);
    chk(!mem_rd_valid && !done_valid, "R9 reset idle", 64'(mem_rd_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // segment start, 2 GB space
    mkchain(64'h0000_0000_1234_5ABC, 0, 64'h0010_0000, 64'h0100_0000, 64'h0000_00AB_CDE0_0000, -1);
    run(64'h0000_0000_1234_5ABC, 0, 64'h0010_0000, 0, 1);
    // R3: segment start with nonzero region-third index
    run(64'h0000_0000_8000_0000, 0, 64'h0010_0000, 0, 0);
    // full five-level walk
    mkchain(64'hFFE0_1234_5678_9ABC, 3, 64'h0020_0000, 64'h0200_0000, 64'h0000_1111_2222_3000, -1);
    run(64'hFFE0_1234_5678_9ABC, 3, 64'h0020_0000, 0, 0);
    // R3: region-second start with region-first index nonzero
    run(64'h0020_0000_0000_0000, 2, 64'h0030_0000, 0, 0);
    // region-second start, back-pressure and ignored request, long latency
    mkchain(64'h001F_FC00_0000_0123, 2, 64'h0040_0000, 64'h0400_0000, 64'h0000_0000_7777_7000, -1);
    run(64'h001F_FC00_0000_0123, 2, 64'h0040_0000, 3, 3);
    // region-third start
    mkchain(64'h0000_03FF_FFFF_F000, 1, 64'h0050_0000, 64'h0500_0000, 64'h0000_0000_0ABC_D000, -1);
    run(64'h0000_03FF_FFFF_F000, 1, 64'h0050_0000, 1, 2);
    // higher start than needed is allowed
    mkchain(64'h0000_0000_0000_0777, 3, 64'h0060_0000, 64'h0600_0000, 64'h0000_0000_0000_5000, -1);
    run(64'h0000_0000_0000_0777, 3, 64'h0060_0000, 0, 1);
    // R4: invalid entry at each level
    for (int b = 4; b >= 0; b--) begin
      logic [63:0] root = 64'h0800_0000 + 64'(b) * 64'h0100_0000;
      mkchain(64'hFFE0_1234_5678_9ABC, 3, root, root + 64'h0010_0000, 64'h0000_0000_9999_9000, b);
      run(64'hFFE0_1234_5678_9ABC, 3, root, 0, 1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule